// File: doc/BRIEF.md
# Gated Countdown Event Timer

A single-channel 32-bit countdown timer that software uses to schedule its next timer event. A control word holds a clock-enable bit, an interrupt-enable bit and a write-one clear bit. A value word is written with a tick count; that write loads the counter and starts the countdown. The counter steps down once on each clock cycle in which the tick enable input is high.

The clock-enable bit gates everything that moves. With it low, the counter holds, value writes are dropped, and the interrupt enable cannot be set. When the count reaches zero the timer raises a pending flag and stops without reloading. The interrupt line is high while the flag is pending and interrupts are enabled. Software clears the flag by writing the clear bit together with the clock-enable bit. The usual sequence to arm the timer is: set the enable, write the tick count, then set enable and interrupt enable.

Top module: `evt_countdown_timer`

## Requirements
- R1: After reset the control word and the value word both read 0 and `irq` is low.
- R2: The control word sits at byte offset 0x40. A write sets the clock enable from bit 0. Reads return the clock enable in bit 0, the interrupt enable in bit 1 and 0 in every other bit, including bit 4. Writing 0 disables the timer. Any offset other than 0x40 and 0x44 reads as 0.
- R3: The interrupt enable is taken from bit 1 of a control write only when bit 0 of the same write is 1. Otherwise the interrupt enable becomes 0.
- R4: A write to the value word at offset 0x44 while the clock enable is set loads the tick count and starts the countdown. Reads of 0x44 return the remaining count.
- R5: A value write while the clock enable is clear is ignored, and the count holds.
- R6: While the clock enable is set and a countdown runs, the count drops by one in each cycle with `tick_en` high. It holds in cycles with `tick_en` low.
- R7: When the count reaches 0, the pending flag is set and the counter stops at 0 without reloading. `irq` is high exactly while the flag is pending and the interrupt enable is set.
- R8: A control write with bit 4 and bit 0 both set clears the pending flag. If bit 1 is low in that write, the interrupt stays disabled. A control write with bit 0 low leaves the flag unchanged.
- R9: If an expiry and a clearing control write fall in the same cycle, the pending flag stays set.
- R10: Loading 0 starts no countdown and raises no event. Loading 0xFFFFFFFF holds the full count and counts down from it.
- R11: Clearing the clock enable during a countdown freezes the count. Setting it again resumes from the frozen count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset of the accessed word |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| tick_en | input | 1 | Count-down qualifier, one step per cycle while high |
| irq | output | 1 | Interrupt, high while pending and enabled |

## Verification
The expiry of the count and a software clear of the pending flag can land on the same clock edge. The bench provokes this by loading a count of 2 and stepping it once. It then holds `tick_en` high in the very cycle it writes the control word with enable, interrupt enable and clear. `irq` is judged one cycle later and must still be high, because the new event wins over the clear. A second clear must then bring it low.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam logic [7:0] CTRL_OFS = 8'h40;
  localparam logic [7:0] VAL_OFS  = 8'h44;
  localparam int unsigned EN_BIT  = 0;
  localparam int unsigned IE_BIT  = 1;
  localparam int unsigned CLR_BIT = 4;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic              en_o,
  output logic              irq_en_o,
  output logic              pending_o
);
  logic en_q, en_d;
  logic ie_q, ie_d;
  logic pend_q, pend_d;

  always_comb begin
    en_d   = en_q;
    ie_d   = ie_q;
    pend_d = pend_q;
    if (wr_ctrl_i) begin
      en_d = wdata_i[EN_BIT];
      ie_d = wdata_i[EN_BIT] & wdata_i[IE_BIT];
      if (wdata_i[EN_BIT] && wdata_i[CLR_BIT]) pend_d = 1'b0;
    end
    if (expire_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      ie_q   <= ie_d;
      pend_q <= pend_d;
    end
  end

  assign en_o      = en_q;
  assign irq_en_o  = ie_q;
  assign pending_o = pend_q;

  // R9: an expiry always leaves the flag pending
  p_expire_sets_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> pend_q);
  // R3: interrupt enable never stands without clock enable
  p_ie_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ie_q |-> en_q);
  // R8: a gated clear with no competing expiry drops the flag
  p_clear_works_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i && wdata_i[EN_BIT] && wdata_i[CLR_BIT] && !expire_i) |=> !pend_q);
  // R2: writing zero disables the timer
  p_zero_disables_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl_i && wdata_i == '0) |=> (!en_q && !ie_q));
endmodule

// File: rtl/evt_down_counter.sv
module evt_down_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             step;

  assign step = en_i & tick_i & run_q & ~load_i;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (load_i) begin
      cnt_d = load_val_i;
      run_d = (load_val_i != '0);
    end else if (step) begin
      cnt_d = cnt_q - ONE;
      if (cnt_q == ONE) run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign count_o  = cnt_q;
  assign expire_o = step & (cnt_q == ONE);

  // R6: no movement while the clock enable is clear
  p_hold_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i) |=> $stable(cnt_q));
  // R7: a stopped counter rests at zero
  p_idle_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (cnt_q == '0));
  // R7: after expiry the counter is stopped, no reload
  p_no_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (!run_q && cnt_q == '0));
endmodule

// File: rtl/evt_countdown_timer.sv
module evt_countdown_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_en,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(VAL_OFS);

  logic              rst_n_i;
  logic              sel_ctrl, sel_val;
  logic              wr_ctrl, wr_val, load;
  logic              en, irq_en, pending, expire;
  logic [DATA_W-1:0] count;

  evt_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_i)
  );

  assign sel_ctrl = (reg_addr == A_CTRL);
  assign sel_val  = (reg_addr == A_VAL);
  assign wr_ctrl  = reg_wr & sel_ctrl;
  assign wr_val   = reg_wr & sel_val;
  assign load     = wr_val & en;

  evt_ctrl_regs #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .wr_ctrl_i (wr_ctrl),
    .wdata_i   (reg_wdata),
    .expire_i  (expire),
    .en_o      (en),
    .irq_en_o  (irq_en),
    .pending_o (pending)
  );

  evt_down_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .en_i       (en),
    .tick_i     (tick_en),
    .load_i     (load),
    .load_val_i (reg_wdata),
    .count_o    (count),
    .expire_o   (expire)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_ctrl) begin
      reg_rdata[EN_BIT] = en;
      reg_rdata[IE_BIT] = irq_en;
    end else if (sel_val) begin
      reg_rdata = count;
    end
  end

  assign irq = pending & irq_en;

  // R5: value writes without clock enable leave the count untouched
  p_ignore_val_off_r5: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_val && !en) |=> $stable(count));
endmodule

// File: tb/evt_countdown_timer_tb.sv
`timescale 1ns/1ps
module evt_countdown_timer_tb;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_TK = 3'd2,
                         OP_ID = 3'd3, OP_IQ = 3'd4;
  localparam int NV = 55;

  function automatic logic [78:0] mk(input logic [2:0] op, input logic [7:0] a,
                                     input logic [31:0] d, input logic [31:0] e,
                                     input logic [3:0] rq);
    return {op, a, d, e, rq};
  endfunction

  localparam logic [78:0] VEC [NV] = '{
    mk(OP_RD, 8'h40, 0, 0, 1),            // R1 control reset
    mk(OP_RD, 8'h44, 0, 0, 1),            // R1 value reset
    mk(OP_IQ, 0, 0, 0, 1),                // R1 irq reset
    mk(OP_WR, 8'h44, 5, 0, 5),            // R5 write while disabled
    mk(OP_RD, 8'h44, 0, 0, 5),            // R5 ignored
    mk(OP_WR, 8'h40, 2, 0, 3),            // R3 bit1 without bit0
    mk(OP_RD, 8'h40, 0, 0, 3),            // R3 not taken
    mk(OP_WR, 8'h40, 32'h13, 0, 2),       // R2 enable, ie, clear
    mk(OP_RD, 8'h40, 0, 3, 2),            // R2 bit4 reads 0
    mk(OP_RD, 8'h48, 0, 0, 2),            // R2 unmapped reads 0
    mk(OP_WR, 8'h44, 5, 0, 4),            // R4 load
    mk(OP_RD, 8'h44, 0, 5, 4),            // R4 readback
    mk(OP_TK, 0, 2, 0, 6),                // R6 two ticks
    mk(OP_RD, 8'h44, 0, 3, 6),
    mk(OP_ID, 0, 3, 0, 6),                // R6 tick_en low
    mk(OP_RD, 8'h44, 0, 3, 6),
    mk(OP_TK, 0, 2, 0, 7),
    mk(OP_RD, 8'h44, 0, 1, 7),
    mk(OP_IQ, 0, 0, 0, 7),                // R7 not yet
    mk(OP_TK, 0, 1, 0, 7),
    mk(OP_RD, 8'h44, 0, 0, 7),
    mk(OP_IQ, 0, 0, 1, 7),                // R7 fires
    mk(OP_TK, 0, 3, 0, 7),
    mk(OP_RD, 8'h44, 0, 0, 7),            // R7 no reload
    mk(OP_IQ, 0, 0, 1, 7),
    mk(OP_WR, 8'h40, 32'h10, 0, 8),       // R8 clear with bit0 low
    mk(OP_IQ, 0, 0, 0, 8),
    mk(OP_WR, 8'h40, 3, 0, 8),
    mk(OP_IQ, 0, 0, 1, 8),                // R8 flag survived
    mk(OP_WR, 8'h40, 32'h11, 0, 8),       // R8 clear, ie low
    mk(OP_IQ, 0, 0, 0, 8),
    mk(OP_RD, 8'h40, 0, 1, 8),
    mk(OP_WR, 8'h40, 3, 0, 8),
    mk(OP_IQ, 0, 0, 0, 8),                // R8 flag gone
    mk(OP_WR, 8'h44, 0, 0, 10),           // R10 load zero
    mk(OP_RD, 8'h44, 0, 0, 10),
    mk(OP_TK, 0, 4, 0, 10),
    mk(OP_IQ, 0, 0, 0, 10),
    mk(OP_WR, 8'h44, 32'hFFFF_FFFF, 0, 10), // R10 maximum
    mk(OP_RD, 8'h44, 0, 32'hFFFF_FFFF, 10),
    mk(OP_TK, 0, 1, 0, 10),
    mk(OP_RD, 8'h44, 0, 32'hFFFF_FFFE, 10),
    mk(OP_WR, 8'h44, 4, 0, 11),           // R11 load 4
    mk(OP_TK, 0, 1, 0, 11),
    mk(OP_RD, 8'h44, 0, 3, 11),
    mk(OP_WR, 8'h40, 0, 0, 11),           // R11 freeze
    mk(OP_TK, 0, 2, 0, 11),
    mk(OP_RD, 8'h44, 0, 3, 11),
    mk(OP_IQ, 0, 0, 0, 11),
    mk(OP_WR, 8'h40, 3, 0, 11),           // R11 resume
    mk(OP_TK, 0, 3, 0, 11),
    mk(OP_IQ, 0, 0, 1, 11),
    mk(OP_RD, 8'h44, 0, 0, 11),
    mk(OP_WR, 8'h40, 32'h13, 0, 8),
    mk(OP_IQ, 0, 0, 0, 8)
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] reg_wdata;
  logic [DW-1:0] reg_rdata;
  logic          tick_en;
  logic          irq;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done = 0;

  always #4 clk = ~clk;

  evt_countdown_timer #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tick_en(tick_en), .irq(irq)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input int rq,
                     input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [7:0] a, input logic [31:0] e, input int rq);
    reg_addr = a;
    #1;
    chk(reg_rdata, e, rq, "read");
  endtask

  task automatic do_iq(input logic e, input int rq);
    #1;
    chk({31'd0, irq}, {31'd0, e}, rq, "irq");
  endtask

  task automatic do_tk(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  op;
      logic [7:0]  a;
      logic [31:0] d, e;
      logic [3:0]  rq;
      {op, a, d, e, rq} = VEC[i];
      case (op)
        OP_WR: do_wr(a, d);
        OP_RD: do_rd(a, e, int'(rq));
        OP_TK: do_tk(int'(d));
        OP_ID: repeat (int'(d)) @(negedge clk);
        default: do_iq(e[0], int'(rq));
      endcase
    end

    // R9: expiry and clear on the same edge, event must win
    do_wr(8'h44, 2);
    do_tk(1);
    reg_addr = 8'h40; reg_wdata = 32'h13; reg_wr = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_en = 1'b0;
    do_iq(1'b1, 9);
    do_wr(8'h40, 32'h13);
    do_iq(1'b0, 9);

    // R1: asynchronous reset in the middle of a countdown
    do_wr(8'h44, 9);
    do_tk(2);
    rst_n = 1'b0;
    do_rd(8'h44, 0, 1);
    do_rd(8'h40, 0, 1);
    do_iq(1'b0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    do_wr(8'h40, 1);
    do_wr(8'h44, 7);
    do_rd(8'h44, 7, 4);   // R4 operational again after reset

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule